// File: doc/BRIEF.md
# Indirect-Pointer DMA Register Front End

This block is the host-side register front end of a four-channel DMA cell on a bus with no address multiplexing. A host reaches the whole cell through one base address. A write there is a command. Its upper three bits carry an operation code, and its lower five bits carry an index into the cell's internal registers. A read there returns a sticky status byte, which holds terminal-count and abort flags for the receive and transmit sides of two serial channels. The read also empties that byte.

When a base write loads a nonzero index, the next bus access reaches the indexed register instead of the base. That access may be a read or a write. Afterwards the index falls back to zero, so the following access lands on the base again. The transfer engines sit outside this block. Their terminal-count and abort events arrive as one-cycle flag inputs. The channel registers behind the pointer are modelled as plain byte storage. Two command codes set persistent enable levels for two of the channels. Setting an enable does not start a transfer.

Top module: `dma_reg_front`

## Requirements
- R1: While reset is asserted and until the first read, `bus_rdata` is 0, both enable outputs are 0, all status flags are clear, and the pointer selects the base register.
- R2: A read at the base returns the status byte on `bus_rdata` in the cycle after the access. The bit layout is: bit 7 RxA terminal count, bit 6 TxA terminal count, bit 5 RxB terminal count, bit 4 TxB terminal count, bit 3 RxA abort, bit 2 TxA abort, bit 1 RxB abort, bit 0 TxB abort. The inputs map as `evt_tc[3:0]` to bits 7..4 and `evt_abort[3:0]` to bits 3..0.
- R3: A read at the base clears every status flag, so a second read with no new events returns 0.
- R4: A terminal-count or abort event that arrives in the same cycle as a status read stays set and is reported by the next read.
- R5: A write at the base loads bits 4..0 as the pointer. While the pointer is in the range 1..NUM_REGS-1, the next access goes to that register: a write stores the full byte, and a read returns it one cycle later.
- R6: Any access made while the pointer is nonzero, read or write, returns the pointer to the base. The access after it therefore reaches the base register.
- R7: Pointer values from NUM_REGS to 31 read as 0 and ignore writes. An access at such a value still returns the pointer to the base.
- R8: A base write with bits 7..5 = 110 sets `en_txa`, and 111 sets `en_rxb`. Each level then stays set until reset.
- R9: Base writes with bits 7..5 in 000..101 leave both enable outputs unchanged.
- R10: A status flag stays set from its event until a base read. Base writes and indirect accesses do not clear it.
- R11: `bus_rdata` changes only in the cycle after a read access and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | One-cycle access strobe |
| bus_wr | input | 1 | 1 = write access, 0 = read access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after a read |
| evt_tc | input | 4 | Terminal-count pulses, [3]=RxA [2]=TxA [1]=RxB [0]=TxB |
| evt_abort | input | 4 | Abort pulses, same channel order |
| en_txa | output | 1 | TxA channel enable level |
| en_rxb | output | 1 | RxB channel enable level |

## Verification
Two things can land on the same status bit in one cycle: a clear-on-read and a new event from a channel. The bench provokes this by pulsing `evt_abort` or `evt_tc` in exactly the cycle of a base read. It expects the first read to return the old byte and the next read to return the new flag. A second collision is a pointer-consuming access that arrives together with channel events. Beyond the directed cases, a long stretch of pseudo-random accesses mixed with random events is compared on every clock against a behavioural model of status, pointer, storage and enables.

// File: rtl/dma_reg_pkg.sv
`timescale 1ns/1ps
package dma_reg_pkg;
  localparam int DATA_W = 8;
  localparam int PTR_W  = 5;
  localparam int CMD_W  = 3;
  localparam int N_CH   = 4;

  // operation codes carried in the upper bits of a base write
  localparam logic [CMD_W-1:0] OP_EN_TXA = 3'b110;
  localparam logic [CMD_W-1:0] OP_EN_RXB = 3'b111;

  // channel order inside the event vectors (highest index = most significant)
  localparam int CH_RXA = 3;
  localparam int CH_TXA = 2;
  localparam int CH_RXB = 1;
  localparam int CH_TXB = 0;

  function automatic logic [2*N_CH-1:0] pack_flags(input logic [N_CH-1:0] tc,
                                                    input logic [N_CH-1:0] ab);
    return {tc, ab};
  endfunction
endpackage

// File: rtl/dma_ptr_ctl.sv
`timescale 1ns/1ps
module dma_ptr_ctl
  import dma_reg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             wr,
  input  logic [PTR_W-1:0] ptr_field,
  output logic [PTR_W-1:0] ptr_q,
  output logic             at_base
);
  logic [PTR_W-1:0] ptr_d;
  logic             ptr_en;

  assign at_base = (ptr_q == '0);
  assign ptr_en  = acc;

  always_comb begin
    ptr_d = ptr_q;
    if (acc) begin
      // a base write loads the index, every other access consumes it
      ptr_d = (at_base && wr) ? ptr_field : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end
endmodule

// File: rtl/dma_status_reg.sv
`timescale 1ns/1ps
module dma_status_reg
  import dma_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [N_CH-1:0]   evt_tc,
  input  logic [N_CH-1:0]   evt_abort,
  output logic [DATA_W-1:0] st_q
);
  logic [DATA_W-1:0] st_d;
  logic [DATA_W-1:0] set_v;
  logic              st_en;

  assign set_v = pack_flags(evt_tc, evt_abort);
  assign st_en = clr | (|set_v);

  always_comb begin
    // clear first, then merge this cycle's events so none are lost
    st_d = (clr ? '0 : st_q) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= '0;
    else if (st_en) st_q <= st_d;
  end
endmodule

// File: rtl/dma_cmd_dec.sv
`timescale 1ns/1ps
module dma_cmd_dec
  import dma_reg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] op,
  output logic             en_txa,
  output logic             en_rxb
);
  logic set_txa, set_rxb;

  assign set_txa = cmd_wr && (op == OP_EN_TXA);
  assign set_rxb = cmd_wr && (op == OP_EN_RXB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_txa <= 1'b0;
    else if (set_txa) en_txa <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_rxb <= 1'b0;
    else if (set_rxb) en_rxb <= 1'b1;
  end
endmodule

// File: rtl/dma_reg_bank.sv
`timescale 1ns/1ps
module dma_reg_bank
  import dma_reg_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int LAST = NUM_REGS - 1;

  logic [DATA_W-1:0] mem_q [1:LAST];

  for (genvar g = 1; g <= LAST; g++) begin : g_reg
    logic hit;
    assign hit = wr_en && (int'(addr) == g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem_q[g] <= '0;
      else if (hit) mem_q[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 1; i <= LAST; i++) begin
      if (int'(addr) == i) rdata = mem_q[i];
    end
  end
endmodule

// File: rtl/dma_reg_front.sv
`timescale 1ns/1ps
module dma_reg_front
  import dma_reg_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_CH-1:0]   evt_tc,
  input  logic [N_CH-1:0]   evt_abort,
  output logic              en_txa,
  output logic              en_rxb
);
  logic [1:0]        rs_q;
  logic              rst_sync_n;
  logic [PTR_W-1:0]  ptr_q;
  logic              at_base;
  logic              base_rd, base_wr, ind_wr, any_rd;
  logic [DATA_W-1:0] status_q, bank_rdata, rdata_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  assign any_rd  = bus_sel && !bus_wr;
  assign base_rd = any_rd && at_base;
  assign base_wr = bus_sel && bus_wr && at_base;
  assign ind_wr  = bus_sel && bus_wr && !at_base;

  dma_ptr_ctl u_ptr (
    .clk(clk), .rst_n(rst_sync_n), .acc(bus_sel), .wr(bus_wr),
    .ptr_field(bus_wdata[PTR_W-1:0]), .ptr_q(ptr_q), .at_base(at_base)
  );

  dma_status_reg u_stat (
    .clk(clk), .rst_n(rst_sync_n), .clr(base_rd),
    .evt_tc(evt_tc), .evt_abort(evt_abort), .st_q(status_q)
  );

  dma_cmd_dec u_cmd (
    .clk(clk), .rst_n(rst_sync_n), .cmd_wr(base_wr),
    .op(bus_wdata[DATA_W-1 -: CMD_W]), .en_txa(en_txa), .en_rxb(en_rxb)
  );

  dma_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(ind_wr), .addr(ptr_q),
    .wdata(bus_wdata), .rdata(bank_rdata)
  );

  always_comb begin
    rdata_d = at_base ? status_q : bank_rdata;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) bus_rdata <= '0;
    else if (any_rd) bus_rdata <= rdata_d;
  end
endmodule

// File: rtl/dma_reg_front_chk.sv
`timescale 1ns/1ps
module dma_reg_front_chk
  import dma_reg_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [N_CH-1:0]   evt_tc,
  input logic [N_CH-1:0]   evt_abort,
  input logic [PTR_W-1:0]  ptr_q,
  input logic [DATA_W-1:0] status_q,
  input logic              en_txa,
  input logic              en_rxb
);
  logic [DATA_W-1:0] evts;
  logic              rd_at_base;
  assign evts       = {evt_tc, evt_abort};
  assign rd_at_base = bus_sel && !bus_wr && (ptr_q == '0);

  p_clear_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_at_base && evts == '0) |=> (status_q == '0));

  p_event_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (evts != '0) |=> ((status_q & $past(evts)) == $past(evts)));

  p_ptr_oneshot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && ptr_q != '0) |=> (ptr_q == '0));

  p_out_of_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && int'(ptr_q) >= NUM_REGS) |=> (bus_rdata == '0));

  p_txa_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en_txa |=> en_txa);

  p_rxb_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en_rxb |=> en_rxb);

  p_nop_codes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && ptr_q == '0 && bus_wdata[7:5] < 3'd6)
      |=> ($stable(en_txa) && $stable(en_rxb)));

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_at_base |=> ((status_q & $past(status_q)) == $past(status_q)));

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |=> $stable(bus_rdata));
endmodule

bind dma_reg_front dma_reg_front_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_tc(evt_tc),
  .evt_abort(evt_abort), .ptr_q(ptr_q), .status_q(status_q),
  .en_txa(en_txa), .en_rxb(en_rxb)
);

// File: tb/test_dma_reg_front.sv
`timescale 1ns/1ps
module test_dma_reg_front;
  localparam int NREG = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_sel, bus_wr;
  logic [7:0] bus_wdata, bus_rdata;
  logic [3:0] evt_tc, evt_abort;
  logic       en_txa, en_rxb;

  int vectors = 0;
  int errors  = 0;

  // behavioural model state
  bit [7:0] m_st, m_rd;
  bit [7:0] m_mem [32];
  int       m_ptr;
  bit       m_tx, m_rx;

  always #2.5 clk = ~clk;

  dma_reg_front #(.NUM_REGS(NREG)) i_dma_reg_front (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_tc(evt_tc),
    .evt_abort(evt_abort), .en_txa(en_txa), .en_rxb(en_rxb)
  );

  task automatic compare(input string tag);
    vectors++;
    if (bus_rdata !== m_rd || en_txa !== m_tx || en_rxb !== m_rx) begin
      errors++;
      $display("FAIL %s: rdata=%02h en_txa=%0b en_rxb=%0b expected rdata=%02h en_txa=%0b en_rxb=%0b",
               tag, bus_rdata, en_txa, en_rxb, m_rd, m_tx, m_rx);
    end
  endtask

  task automatic step(input bit sel, input bit wr, input bit [7:0] wd,
                      input bit [3:0] tc, input bit [3:0] ab, input string tag);
    int nxt;
    @(negedge clk);
    bus_sel = sel; bus_wr = wr; bus_wdata = wd; evt_tc = tc; evt_abort = ab;
    nxt = m_ptr;
    if (sel && !wr) begin
      if (m_ptr == 0)         m_rd = m_st;
      else if (m_ptr < NREG)  m_rd = m_mem[m_ptr];
      else                    m_rd = 8'h00;
      nxt = 0;
    end
    if (sel && wr) begin
      if (m_ptr == 0) begin
        if (wd[7:5] == 3'b110) m_tx = 1'b1;
        if (wd[7:5] == 3'b111) m_rx = 1'b1;
        nxt = int'(wd[4:0]);
      end else begin
        if (m_ptr < NREG) m_mem[m_ptr] = wd;
        nxt = 0;
      end
    end
    if (sel && !wr && m_ptr == 0) m_st = 8'h00;
    m_st = m_st | {tc, ab};
    m_ptr = nxt;
    @(posedge clk);
    #1;
    compare(tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 8'h00, 4'h0, 4'h0, tag);
  endtask

  task automatic rd(input string tag);
    step(1'b1, 1'b0, 8'h00, 4'h0, 4'h0, tag);
  endtask

  task automatic wr(input bit [7:0] d, input string tag);
    step(1'b1, 1'b1, d, 4'h0, 4'h0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 8'h00;
    evt_tc = 4'h0; evt_abort = 4'h0;
    m_st = 0; m_rd = 0; m_ptr = 0; m_tx = 0; m_rx = 0;
    foreach (m_mem[i]) m_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
    repeat (4) idle("R1 release");
    rd("R1 first status read");

    // R2: each flag reaches its documented bit
    for (int c = 0; c < 4; c++) begin
      step(1'b0, 1'b0, 8'h00, 4'(1 << c), 4'h0, "R2 tc event");
      rd("R2 tc bit");
      step(1'b0, 1'b0, 8'h00, 4'h0, 4'(1 << c), "R2 abort event");
      rd("R2 abort bit");
    end

    // R10 then R3
    step(1'b0, 1'b0, 8'h00, 4'b0101, 4'b1010, "R10 events");
    wr(8'h00, "R10 base write keeps flags");
    idle("R10 idle");
    rd("R10 flags still set");
    rd("R3 cleared by read");

    // R4: event coincides with clearing read
    step(1'b0, 1'b0, 8'h00, 4'b1000, 4'h0, "R4 prior flag");
    step(1'b1, 1'b0, 8'h00, 4'h0, 4'b0001, "R4 read with event");
    rd("R4 event reported next");

    // R5 / R6
    wr(8'h05, "R5 load pointer");
    wr(8'hC3, "R5 indirect write");
    rd("R6 back at base");
    wr(8'h05, "R5 reload pointer");
    step(1'b1, 1'b0, 8'h00, 4'b0010, 4'h0, "R5 indirect read with event");
    rd("R6 base after read");
    wr(8'h0F, "R5 top register");
    wr(8'h5A, "R5 write top");
    wr(8'h0F, "R5 pointer again");
    rd("R5 read top");

    // R7: out of range
    wr(8'h14, "R7 pointer out of range");
    wr(8'hFF, "R7 write ignored");
    wr(8'h14, "R7 pointer again");
    rd("R7 reads zero");
    step(1'b0, 1'b0, 8'h00, 4'h0, 4'b0100, "R7 event");
    rd("R7 consumed, base status");

    // R9 then R8
    for (int k = 0; k < 6; k++) wr(8'(k << 5), "R9 nop code");
    idle("R9 enables unchanged");
    wr(8'hC0, "R8 enable TxA");
    idle("R8 TxA held");
    wr(8'hE0, "R8 enable RxB");
    idle("R8 both held");
    repeat (3) idle("R11 rdata holds");

    // mixed traffic
    for (int n = 0; n < 2000; n++) begin
      bit [31:0] r;
      r = $urandom;
      step(r[0], r[1], r[15:8],
           (r[18:16] == 3'd0) ? r[23:20] : 4'h0,
           (r[26:24] == 3'd0) ? r[31:28] : 4'h0,
           "R2 R5 R6 R10 mixed");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule